// File: doc/BRIEF.md
# Clock Source Selection Fallback Controller

This block decides where a microcontroller-style bus clock comes from. It either uses the PLL output or bypasses the PLL and uses the external oscillator directly. The analog parts are outside the block. The PLL lock indication and the raw oscillator-good indication arrive as asynchronous inputs. The block returns a bus-source select, a PLL post-divider select, a gate for the oscillator clock of the CAN peripheral, and an oscillator enable.

The oscillator counts as usable only when three things hold: it is enabled, its raw indication is good, and the PLL is locked. Losing lock therefore also takes away oscillator validity. When oscillator validity is lost, the block does four things without waiting for software:

- It moves the bus back to the PLL path in the same cycle.
- It latches the select bit to the PLL setting.
- It holds the PLL output at VCO/4.
- It closes the CAN oscillator gate.

Sticky change flags record every transition of the lock and oscillator status. Software clears them by writing one. An interrupt request is raised for each flag whose enable bit is set. To move the bus onto the oscillator, software first enables the oscillator. It then waits until both status outputs read 1, clears the flags, optionally sets the interrupt enables, and finally writes the select bit to 0.

Top module: `clksel_fallback_ctrl`

## Requirements
- R1: After reset, bus_from_pll is 1, osc_enable is 0, pll_div4 is 1, flags and irq_en are 0 and irq is 0.
- R2: lock_async and osc_async pass through a two-flop synchronizer. A change applied between edges shows on lock_sts/osc_sts after the second rising edge, not after the first.
- R3: osc_sts is 1 only when osc_enable, the synchronized lock and the synchronized oscillator input are all 1. When lock is lost, osc_sts drops even if osc_async stays 1.
- R4: pll_div4 is 1 (PLL output is VCO divided by four) whenever osc_sts is 0, and 0 otherwise.
- R5: can_osc_gate equals osc_sts.
- R6: When osc_sts is 0, bus_from_pll is 1 in the same cycle. The select bit is then held at 1, so it stays 1 after osc_sts returns until software writes 0.
- R7: A control write with pll_sel=0 is ignored while osc_sts is 0. It takes effect (bus_from_pll=0) when osc_sts is 1.
- R8: flags bit 0 is set one cycle after lock_sts changes in either direction. flags bit 1 is set one cycle after osc_sts changes. Both bits are sticky.
- R9: flg_clr clears each flag whose flg_clr_mask bit is 1 and leaves flags with mask bit 0 alone. A flag that would be set in the same cycle as its clear stays 1.
- R10: irq_en is written by ien_wr with ien_data (bit 0 lock, bit 1 oscillator). irq is the OR of flags AND irq_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lock_async | input | 1 | Raw PLL lock indication, asynchronous |
| osc_async | input | 1 | Raw oscillator-good indication, asynchronous |
| ctl_wr | input | 1 | Control write strobe |
| ctl_osc_en | input | 1 | Oscillator enable value for a control write |
| ctl_pll_sel | input | 1 | Bus source value for a control write (1 = PLL) |
| flg_clr | input | 1 | Flag clear strobe |
| flg_clr_mask | input | 2 | Flags to clear (bit 0 lock, bit 1 oscillator) |
| ien_wr | input | 1 | Interrupt enable write strobe |
| ien_data | input | 2 | Interrupt enable value |
| osc_enable | output | 1 | Oscillator enable to the analog oscillator |
| bus_from_pll | output | 1 | Bus clock source select, 1 = PLL path |
| pll_div4 | output | 1 | PLL output divider forced to VCO/4 |
| can_osc_gate | output | 1 | Enable for the CAN oscillator clock |
| lock_sts | output | 1 | Synchronized lock status |
| osc_sts | output | 1 | Effective oscillator validity |
| flags | output | 2 | Sticky change flags |
| irq_en | output | 2 | Interrupt enables readback |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can fall in the same cycle, and each is checked.

The first pair is a software flag clear and a new status change. The bench drops lock, counts the two synchronizer edges, and asserts the clear exactly on the edge where the flags would set. Both flags must then read 1.

The second pair is a select write of 0 and a lost oscillator. The bench issues the write while osc_sts is 0 and confirms that bus_from_pll stays 1. A near-exhaustive sweep over enable, lock and oscillator inputs, and over all interrupt-enable patterns, checks the outputs against values the bench computes itself.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
   localparam int FLAG_LOCK = 0;
   localparam int FLAG_OSC  = 1;
   localparam int NFLAGS    = 2;
   typedef logic [NFLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/status_sync.sv
module status_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("status_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d_async;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
      end
   end

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/flag_bank.sv
module flag_bank #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt,
   input  logic         clr_stb,
   input  logic [N-1:0] clr_mask,
   input  logic         ien_wr,
   input  logic [N-1:0] ien_data,
   output logic [N-1:0] flags,
   output logic [N-1:0] ien,
   output logic         irq
);
   if (N < 1) begin : g_bad_n
      $error("flag_bank: N must be positive");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n)                      flags[i] <= 1'b0;
         else if (evt[i])                 flags[i] <= 1'b1;
         else if (clr_stb && clr_mask[i]) flags[i] <= 1'b0;

      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n)      ien[i] <= 1'b0;
         else if (ien_wr) ien[i] <= ien_data[i];
   end

   assign irq = |(flags & ien);
endmodule

// File: rtl/mode_ctrl.sv
module mode_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  logic wr_osc_en,
   input  logic wr_pll_sel,
   input  logic osc_valid,
   output logic osc_en,
   output logic pll_sel
);
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)  osc_en <= 1'b0;
      else if (wr) osc_en <= wr_osc_en;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)          pll_sel <= 1'b1;
      else if (!osc_valid) pll_sel <= 1'b1;
      else if (wr)         pll_sel <= wr_pll_sel;
endmodule

// File: rtl/clksel_fallback_ctrl.sv
module clksel_fallback_ctrl
   import clksel_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lock_async,
   input  logic              osc_async,
   input  logic              ctl_wr,
   input  logic              ctl_osc_en,
   input  logic              ctl_pll_sel,
   input  logic              flg_clr,
   input  logic [NFLAGS-1:0] flg_clr_mask,
   input  logic              ien_wr,
   input  logic [NFLAGS-1:0] ien_data,
   output logic              osc_enable,
   output logic              bus_from_pll,
   output logic              pll_div4,
   output logic              can_osc_gate,
   output logic              lock_sts,
   output logic              osc_sts,
   output logic [NFLAGS-1:0] flags,
   output logic [NFLAGS-1:0] irq_en,
   output logic              irq
);
   logic [1:0] raw_sync;
   logic       lock_s, oscin_s, osc_valid, osc_en_q, pll_sel_q;
   logic       lock_prev, valid_prev;
   flag_vec_t  evt;

   status_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async ({osc_async, lock_async}),
      .q_sync  (raw_sync)
   );

   assign lock_s    = raw_sync[0];
   assign oscin_s   = raw_sync[1];
   assign osc_valid = osc_en_q & lock_s & oscin_s;

   mode_ctrl i_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (ctl_wr),
      .wr_osc_en  (ctl_osc_en),
      .wr_pll_sel (ctl_pll_sel),
      .osc_valid  (osc_valid),
      .osc_en     (osc_en_q),
      .pll_sel    (pll_sel_q)
   );

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         lock_prev  <= 1'b0;
         valid_prev <= 1'b0;
      end else begin
         lock_prev  <= lock_s;
         valid_prev <= osc_valid;
      end

   always_comb begin
      evt            = '0;
      evt[FLAG_LOCK] = lock_s ^ lock_prev;
      evt[FLAG_OSC]  = osc_valid ^ valid_prev;
   end

   flag_bank #(.N(NFLAGS)) i_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt),
      .clr_stb  (flg_clr),
      .clr_mask (flg_clr_mask),
      .ien_wr   (ien_wr),
      .ien_data (ien_data),
      .flags    (flags),
      .ien      (irq_en),
      .irq      (irq)
   );

   assign osc_enable   = osc_en_q;
   assign bus_from_pll = pll_sel_q | ~osc_valid;
   assign pll_div4     = ~osc_valid;
   assign can_osc_gate = osc_valid;
   assign lock_sts     = lock_s;
   assign osc_sts      = osc_valid;
endmodule

// File: rtl/clksel_fallback_chk.sv
module clksel_fallback_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ctl_wr,
   input logic       ctl_pll_sel,
   input logic       flg_clr,
   input logic [1:0] flg_clr_mask,
   input logic       lock_sts,
   input logic       osc_sts,
   input logic       can_osc_gate,
   input logic       pll_div4,
   input logic       bus_from_pll,
   input logic [1:0] flags,
   input logic [1:0] irq_en,
   input logic       irq
);
   a_r3_lock_gates_osc: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_sts |-> !osc_sts);
   a_r4_div4_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
      !can_osc_gate |-> pll_div4);
   a_r6_fallback_to_pll: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_sts |-> bus_from_pll);
   a_r7_ignore_bad_select: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !ctl_pll_sel && !osc_sts) |=> bus_from_pll);
   a_r8_lock_change_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_sts != $past(lock_sts)) |=> flags[0]);
   a_r9_sticky_lock_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[0] && !(flg_clr && flg_clr_mask[0])) |=> flags[0]);
   a_r10_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (|(flags & irq_en)));
endmodule

bind clksel_fallback_ctrl clksel_fallback_chk i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ctl_wr       (ctl_wr),
   .ctl_pll_sel  (ctl_pll_sel),
   .flg_clr      (flg_clr),
   .flg_clr_mask (flg_clr_mask),
   .lock_sts     (lock_sts),
   .osc_sts      (osc_sts),
   .can_osc_gate (can_osc_gate),
   .pll_div4     (pll_div4),
   .bus_from_pll (bus_from_pll),
   .flags        (flags),
   .irq_en       (irq_en),
   .irq          (irq)
);

// File: tb/test_clksel_fallback_ctrl.sv
module test_clksel_fallback_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lock_async = 1'b0, osc_async = 1'b0;
   logic       ctl_wr = 1'b0, ctl_osc_en = 1'b0, ctl_pll_sel = 1'b1;
   logic       flg_clr = 1'b0;
   logic [1:0] flg_clr_mask = 2'b00;
   logic       ien_wr = 1'b0;
   logic [1:0] ien_data = 2'b00;
   logic       osc_enable, bus_from_pll, pll_div4, can_osc_gate;
   logic       lock_sts, osc_sts, irq;
   logic [1:0] flags, irq_en;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;

   clksel_fallback_ctrl i_clksel_fallback_ctrl (.*);

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr_ctl(input logic en, input logic sel);
      ctl_wr = 1'b1; ctl_osc_en = en; ctl_pll_sel = sel;
      tick(1);
      ctl_wr = 1'b0;
   endtask

   task automatic clr_flags(input logic [1:0] m);
      flg_clr = 1'b1; flg_clr_mask = m;
      tick(1);
      flg_clr = 1'b0; flg_clr_mask = 2'b00;
   endtask

   task automatic wr_ien(input logic [1:0] v);
      ien_wr = 1'b1; ien_data = v;
      tick(1);
      ien_wr = 1'b0;
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      chk("R1 bus_from_pll", bus_from_pll, 1);
      chk("R1 osc_enable", osc_enable, 0);
      chk("R1 pll_div4", pll_div4, 1);
      chk("R1 flags", flags, 0);
      chk("R1 irq_en", irq_en, 0);
      chk("R1 irq", irq, 0);

      // R2 synchronizer latency
      lock_async = 1'b1; osc_async = 1'b1;
      tick(1);
      chk("R2 lock after one edge", lock_sts, 0);
      tick(1);
      chk("R2 lock after two edges", lock_sts, 1);
      tick(1);
      chk("R8 lock flag set", flags[0], 1);
      chk("R8 osc flag untouched", flags[1], 0);
      tick(2);
      chk("R8 lock flag sticky", flags[0], 1);
      clr_flags(2'b11);
      chk("R9 clear all", flags, 0);

      // R3 R4 R5 sweep
      for (int v = 0; v < 8; v++) begin
         logic e, l, o, x;
         e = v[0]; l = v[1]; o = v[2];
         x = e & l & o;
         lock_async = l; osc_async = o;
         wr_ctl(e, 1'b1);
         tick(3);
         chk("R3 osc_sts sweep", osc_sts, x);
         chk("R4 pll_div4 sweep", pll_div4, !x);
         chk("R5 can gate sweep", can_osc_gate, x);
      end

      // valid state, select oscillator
      lock_async = 1'b1; osc_async = 1'b1;
      wr_ctl(1'b1, 1'b1);
      tick(3);
      clr_flags(2'b11);
      wr_ctl(1'b1, 1'b0);
      chk("R7 select accepted", bus_from_pll, 0);
      osc_async = 1'b0;
      tick(1);
      chk("R6 before sync", bus_from_pll, 0);
      tick(1);
      chk("R6 immediate fallback", bus_from_pll, 1);
      chk("R4 div4 on loss", pll_div4, 1);
      tick(1);
      chk("R8 osc flag set", flags[1], 1);
      osc_async = 1'b1;
      tick(4);
      chk("R6 select held", bus_from_pll, 1);
      chk("R5 gate back", can_osc_gate, 1);

      // R7 ignored write while invalid
      osc_async = 1'b0;
      tick(3);
      wr_ctl(1'b1, 1'b0);
      tick(1);
      chk("R7 write ignored", bus_from_pll, 1);
      osc_async = 1'b1;
      tick(3);
      chk("R7 still pll after recovery", bus_from_pll, 1);
      wr_ctl(1'b1, 1'b0);
      chk("R7 write accepted", bus_from_pll, 0);

      // R9 clear colliding with change
      clr_flags(2'b11);
      chk("R9 cleared", flags, 0);
      lock_async = 1'b0;
      tick(1);
      tick(1);
      chk("R3 lock loss kills osc", osc_sts, 0);
      chk("R6 fallback on lock loss", bus_from_pll, 1);
      flg_clr = 1'b1; flg_clr_mask = 2'b11;
      tick(1);
      flg_clr = 1'b0; flg_clr_mask = 2'b00;
      chk("R9 set wins over clear", flags, 2'b11);
      clr_flags(2'b01);
      chk("R9 mask leaves other", flags, 2'b10);

      // R10 interrupt sweep
      lock_async = 1'b1;
      tick(3);
      chk("R8 both flags", flags, 2'b11);
      for (int m = 0; m < 4; m++) begin
         wr_ien(m[1:0]);
         chk("R10 irq_en", irq_en, m[1:0]);
         chk("R10 irq", irq, (m != 0));
      end
      clr_flags(2'b01);
      for (int m = 0; m < 4; m++) begin
         wr_ien(m[1:0]);
         chk("R10 irq one flag", irq, m[1]);
      end
      clr_flags(2'b11);
      chk("R10 irq no flags", irq, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule